// File: doc/BRIEF.md
# Mode-Dependent Synchronization Clock Generator

This block derives a square-wave synchronization clock from a fast system clock. A master converter drives it out so that several slave devices can line up their internal timing with the master. The division ratio depends on the operating mode and on the interpolation factor of the datapath. In single-tone operation, or whenever the interpolation filter is bypassed, the output period is 16 system clocks. When the filter is active, a divide-by-16 prescaler feeds a divide-by-2R postscaler, so the period is 32·R system clocks.

A polarity control selects whether the output transitions are aligned to the rising or to the falling edge of the system clock. An enable control starts and stops the output synchronously. Any change of mode, factor, enable or polarity restarts the divider, so no shortened pulse can leave the block. A 5-bit fine-delay code is registered and carried on an output port to an external delay element.

Top module: `sync_clk_gen`

## Requirements
- R1: While running, `sync_out` is a square wave whose high time equals exactly half its period, counted in system-clock cycles.
- R2: With `mode` = 2'b00 (single tone), or with `mode` = 2'b01 (quadrature modulation) or 2'b10 (interpolating DAC) and `interp_r` = 1, the period of `sync_out` is 16 cycles.
- R3: With `mode` = 2'b01 or 2'b10 and `interp_r` = R in the range 2 to 63, the period of `sync_out` is 32·R cycles.
- R4: An `interp_r` of 0 behaves as 1, and the reserved `mode` = 2'b11 behaves as single tone (period 16).
- R5: With `edge_sel` = 0, `sync_out` changes only at rising system-clock edges.
- R6: With `edge_sel` = 1, `sync_out` changes only at falling system-clock edges.
- R7: Whenever `gen_en` has been 0 for two consecutive cycles, `sync_out` is 0.
- R8: A change of `mode`, `interp_r`, `gen_en` or `edge_sel` restarts the divider with the output low, and the first high pulse after the change has the full new width.
- R9: `dly_code` equals the value `dly_word` had one cycle earlier and stays unchanged while `dly_word` is unchanged.
- R10: During reset `sync_out` is 0 and `dly_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 single tone, 01 quadrature modulation, 10 interpolating DAC, 11 reserved |
| interp_r | input | R_W | Interpolation factor R, 0 treated as 1 |
| gen_en | input | 1 | Output enable |
| edge_sel | input | 1 | 0 aligns to rising edges, 1 aligns to falling edges |
| dly_word | input | DLY_W | Fine-delay code for the external delay element |
| sync_out | output | 1 | Synchronization clock |
| dly_code | output | DLY_W | Registered fine-delay code |

## Verification
The critical overlap is a configuration change that arrives in the same cycle as a divider toggle or during a high phase. At that point the restart and the phase flip compete for the output register. The bench changes the factor from 2 to 3 in the middle of a high pulse. It requires the output to drop at once and requires the next high pulse to last exactly the new 48 cycles. Polarity is judged by sampling the output just after every rising edge and just after every falling edge, and by counting on which side each transition appears.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

  typedef enum logic [1:0] {
    MODE_TONE = 2'b00,
    MODE_QMOD = 2'b01,
    MODE_IDAC = 2'b10,
    MODE_RSVD = 2'b11
  } sync_mode_e;

  function automatic logic mode_is_bypass(input sync_mode_e m);
    return (m == MODE_TONE) || (m == MODE_RSVD);
  endfunction

endpackage

// File: rtl/sync_rst_bridge.sv
module sync_rst_bridge (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_s = stage_q[1];
endmodule

// File: rtl/sync_cfg_stage.sv
module sync_cfg_stage
  import sync_gen_pkg::*;
#(
  parameter int R_W   = 6,
  parameter int DLY_W = 5,
  localparam int POST_W = R_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [R_W-1:0]    r_i,
  input  logic              en_i,
  input  logic              pol_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic [POST_W-1:0] k_o,
  output logic              en_o,
  output logic              pol_o,
  output logic              restart_o,
  output logic [DLY_W-1:0]  dly_o
);
  sync_mode_e     mode_q, mode_d;
  logic [R_W-1:0] r_q, r_d;
  logic           en_q, en_d;
  logic           pol_q, pol_d;
  logic [DLY_W-1:0] dly_q;
  logic           dly_ce;
  logic           bypass;

  always_comb begin
    mode_d = sync_mode_e'(mode_i);
    r_d    = (r_i == '0) ? R_W'(1) : r_i;
    en_d   = en_i;
    pol_d  = pol_i;
    restart_o = (mode_d != mode_q) || (r_d != r_q) ||
                (en_d != en_q) || (pol_d != pol_q);
    dly_ce = (dly_i != dly_q);
    bypass = mode_is_bypass(mode_q) || (r_q == R_W'(1));
    k_o    = bypass ? POST_W'(1) : {r_q, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TONE;
      r_q    <= R_W'(1);
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
    end else if (restart_o) begin
      mode_q <= mode_d;
      r_q    <= r_d;
      en_q   <= en_d;
      pol_q  <= pol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (dly_ce) dly_q <= dly_i;
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign dly_o = dly_q;
endmodule

// File: rtl/sync_div_core.sv
module sync_div_core #(
  parameter int PRE_HALF = 8,
  parameter int POST_W   = 7,
  localparam int PRE_W   = (PRE_HALF > 1) ? $clog2(PRE_HALF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [POST_W-1:0] k,
  output logic              tick,
  output logic              ph
);
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [POST_W-1:0] post_q, post_d;
  logic              ph_q, ph_d;
  logic              pre_wrap, post_wrap;

  always_comb begin
    pre_wrap  = (pre_q == PRE_W'(PRE_HALF - 1));
    post_wrap = (post_q == (k - POST_W'(1)));
    tick      = run && pre_wrap;
    pre_d     = pre_q;
    post_d    = post_q;
    ph_d      = ph_q;
    if (!run) begin
      pre_d  = '0;
      post_d = '0;
      ph_d   = 1'b0;
    end else begin
      pre_d = pre_wrap ? '0 : pre_q + PRE_W'(1);
      if (tick) begin
        post_d = post_wrap ? '0 : post_q + POST_W'(1);
        if (post_wrap) ph_d = ~ph_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
      ph_q   <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      post_q <= post_d;
      ph_q   <= ph_d;
    end
  end

  assign ph = ph_q;
endmodule

// File: rtl/sync_edge_out.sv
module sync_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic ph,
  input  logic pol,
  output logic out
);
  logic fall_q, fall_d;

  always_comb fall_d = ph;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= fall_d;
  end

  always_comb out = pol ? fall_q : ph;
endmodule

// File: rtl/sync_clk_gen.sv
module sync_clk_gen #(
  parameter int R_W      = 6,
  parameter int DLY_W    = 5,
  parameter int PRE_HALF = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [R_W-1:0]   interp_r,
  input  logic             gen_en,
  input  logic             edge_sel,
  input  logic [DLY_W-1:0] dly_word,
  output logic             sync_out,
  output logic [DLY_W-1:0] dly_code
);
  localparam int POST_W = R_W + 1;

  logic              rst_n_s;
  logic [POST_W-1:0] k_val;
  logic              en_q, pol_q, restart, run, tick, ph;

  sync_rst_bridge u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  sync_cfg_stage #(.R_W(R_W), .DLY_W(DLY_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mode_i    (mode),
    .r_i       (interp_r),
    .en_i      (gen_en),
    .pol_i     (edge_sel),
    .dly_i     (dly_word),
    .k_o       (k_val),
    .en_o      (en_q),
    .pol_o     (pol_q),
    .restart_o (restart),
    .dly_o     (dly_code)
  );

  assign run = en_q && !restart;

  sync_div_core #(.PRE_HALF(PRE_HALF), .POST_W(POST_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (run),
    .k     (k_val),
    .tick  (tick),
    .ph    (ph)
  );

  sync_edge_out u_out (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ph    (ph),
    .pol   (pol_q),
    .out   (sync_out)
  );
endmodule

// File: rtl/sync_clk_gen_chk.sv
module sync_clk_gen_chk #(
  parameter int DLY_W = 5
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             gen_en,
  input logic [DLY_W-1:0] dly_word,
  input logic [DLY_W-1:0] dly_code,
  input logic             sync_out,
  input logic             restart,
  input logic             run,
  input logic             tick,
  input logic             ph
);
  logic past_valid;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) past_valid <= 1'b0;
    else          past_valid <= 1'b1;
  end

  AST_PHASE_FLIP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (past_valid && (ph != $past(ph))) |-> ($past(tick) || !$past(run))); // R1

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (past_valid && !gen_en && !$past(gen_en)) |-> !sync_out); // R7

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (past_valid && $past(restart)) |-> !ph); // R8

  AST_DELAY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    past_valid |-> (dly_code == $past(dly_word))); // R9
endmodule

bind sync_clk_gen sync_clk_gen_chk #(.DLY_W(DLY_W)) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .gen_en   (gen_en),
  .dly_word (dly_word),
  .dly_code (dly_code),
  .sync_out (sync_out),
  .restart  (restart),
  .run      (run),
  .tick     (tick),
  .ph       (ph)
);

// File: tb/sync_clk_gen_test.sv
module sync_clk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [5:0] interp_r = 6'd1;
  logic       gen_en = 1'b0;
  logic       edge_sel = 1'b0;
  logic [4:0] dly_word = 5'd7;
  logic       sync_out;
  logic [4:0] dly_code;

  int n_chk = 0;
  int n_bad = 0;
  logic a_s = 1'b0;
  logic b_s = 1'b0;
  int chg_p = 0;
  int chg_n = 0;

  always #2 clk = ~clk;

  sync_clk_gen uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .interp_r(interp_r),
    .gen_en(gen_en), .edge_sel(edge_sel), .dly_word(dly_word),
    .sync_out(sync_out), .dly_code(dly_code)
  );

  typedef struct packed {
    logic [1:0] md;
    logic [5:0] r;
    logic       pol;
    logic [15:0] half;
    logic [3:0] tag;
  } vec_t;

  // tag: 2 = R2, 3 = R3, 4 = R4
  localparam vec_t VEC [10] = '{
    '{2'b00, 6'd5,  1'b0, 16'd8,    4'd2},
    '{2'b01, 6'd1,  1'b1, 16'd8,    4'd2},
    '{2'b10, 6'd1,  1'b0, 16'd8,    4'd2},
    '{2'b01, 6'd0,  1'b1, 16'd8,    4'd4},
    '{2'b11, 6'd9,  1'b0, 16'd8,    4'd4},
    '{2'b10, 6'd2,  1'b0, 16'd32,   4'd3},
    '{2'b01, 6'd3,  1'b1, 16'd48,   4'd3},
    '{2'b10, 6'd5,  1'b1, 16'd80,   4'd3},
    '{2'b01, 6'd7,  1'b0, 16'd112,  4'd3},
    '{2'b01, 6'd63, 1'b1, 16'd1008, 4'd3}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: sample just after the rising edge, then just after the falling edge
  task automatic step();
    @(posedge clk); #1;
    if (sync_out != b_s) chg_p++;
    a_s = sync_out;
    @(negedge clk); #1;
    if (sync_out != a_s) chg_n++;
    b_s = sync_out;
  endtask

  task automatic measure(input int lim, output int hi, output int per, output bit ok);
    int n;
    n = 0; hi = 0; per = 0; ok = 1'b1;
    while (a_s && n < lim) begin step(); n++; end
    while (!a_s && n < lim) begin step(); n++; end
    if (n >= lim) begin ok = 1'b0; return; end
    chg_p = 0; chg_n = 0;
    while (a_s && n < lim) begin hi++; step(); n++; end
    per = hi;
    while (!a_s && n < lim) begin per++; step(); n++; end
    if (n >= lim) ok = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi, per, cnt;
    bit ok;
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(sync_out == 1'b0, "R10 sync_out in reset", sync_out, 0);
    chk(dly_code == 5'd0, "R10 dly_code in reset", dly_code, 0);
    @(negedge clk); rst_n = 1'b1;
    gen_en = 1'b1;
    repeat (4) step();

    // table walk: R1 duty, R2/R3/R4 period, R5/R6 edge alignment
    foreach (VEC[i]) begin
      mode = VEC[i].md; interp_r = VEC[i].r; edge_sel = VEC[i].pol;
      measure(4 * int'(VEC[i].half) + 64, hi, per, ok);
      chk(ok, "R1 pulse seen", ok, 1);
      chk(hi == int'(VEC[i].half), "R1 high time", hi, int'(VEC[i].half));
      chk(per == 2 * int'(VEC[i].half), tag_name(VEC[i].tag), per, 2 * int'(VEC[i].half));
      if (VEC[i].pol) chk(chg_p == 0 && chg_n > 0, "R6 falling-edge alignment", chg_p, 0);
      else            chk(chg_n == 0 && chg_p > 0, "R5 rising-edge alignment", chg_n, 0);
    end

    // R8: change factor in the middle of a high pulse
    mode = 2'b01; interp_r = 6'd2; edge_sel = 1'b0;
    measure(200, hi, per, ok);
    chk(hi == 32, "R8 baseline high", hi, 32);
    while (!a_s) step();
    repeat (5) step();
    interp_r = 6'd3;
    step(); step();
    chk(a_s == 1'b0, "R8 output low after restart", a_s, 0);
    measure(300, hi, per, ok);
    chk(hi == 48, "R8 first pulse full width", hi, 48);
    chk(per == 96, "R8 first period", per, 96);

    // R7: disabled output stays low
    gen_en = 1'b0;
    step(); step();
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      step();
      if (a_s || b_s) cnt++;
    end
    chk(cnt == 0, "R7 low while disabled", cnt, 0);
    gen_en = 1'b1;
    measure(300, hi, per, ok);
    chk(hi == 48 && per == 96, "R7 resumes after enable", per, 96);

    // R9: delay code follows one cycle later and holds
    dly_word = 5'd19;
    step();
    chk(dly_code == 5'd19, "R9 code follows", dly_code, 19);
    cnt = 0;
    for (int k = 0; k < 120; k++) begin
      step();
      if (dly_code != 5'd19) cnt++;
    end
    chk(cnt == 0, "R9 code held stable", cnt, 0);
    dly_word = 5'd31;
    step();
    chk(dly_code == 5'd31, "R9 top code", dly_code, 31);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule